// File: doc/BRIEF.md
# Line Reference Window and Field Gating

This block turns free-running column and row counts from an image sensor readout into a horizontal reference strobe (`href`). It also produces a pixel output bus that can be delayed, doubled or blanked. The window edges are programmed in coarse horizontal units and in scan lines. Only window settings that pass a range and ordering check can open the window.

A two-bit field mode selects whether the strobe appears in odd fields, even fields, both, or neither. In the single-parity modes, a skip count N shows only one selected field in every N. A field that the skipper hides carries the black level on the pixel bus. A pixel shift delays data against the strobe by up to 255 clocks, using a ring buffer that maps to block RAM. A doubling control stretches each line and repeats every sample.

All programmable inputs are sampled only on a `field_start` pulse. The counters and the field flag are driven by the surrounding timing generator.

Top module: `href_gate`

## Requirements
- R1: `href` rises one clock after a column/row pair inside the window: hstart <= U < hend and vstart <= row < vend. U is `pix_col` shifted right by (1 if `cfg_qcif`=0, else 0) plus (1 if `cfg_dbl`=1).
- R2: The horizontal settings are legal when hstart is in 0x38..0xEB, hend is in 0x39..0xEC and hstart < hend. With any illegal setting, `href` stays low and `win_err` is 1 from the clock after the setting becomes active.
- R3: The vertical settings are legal when vstart is in 0x03..0x93, vend is in 0x04..0x94 and vstart < vend. Otherwise they are treated as in R2, and `href` never rises outside the vertical window.
- R4: Field mode 2'b00 never raises `href`. 2'b01 allows it only in a field whose `field_odd` was 1 at its `field_start`. 2'b10 allows it only in fields whose flag was 0. 2'b11 allows it in every field.
- R5: In modes 2'b01 and 2'b10, the fields of the selected parity are counted. The first one after the count restarts is shown, and the next N-1 are hidden, where N is `cfg_skip` and a value of 0 acts as 1.
- R6: In modes 2'b00 and 2'b11 the skip count has no effect, and the skip counter returns to its start.
- R7: During a hidden field, `href` stays low and `pix_out` equals the BLACK parameter (default 8'h10).
- R8: `pix_out` one clock after step t carries the sample of step t-S, where S is the active shift (0..255). S has no effect on `href`.
- R9: With doubling on, a step with an odd column repeats the sample taken at the step before it, so each sample is output twice.
- R10: Reset sets hstart 0x38, hend 0xEA, vstart 0x03, vend 0x92, shift 0, mode 2'b11, skip 1, doubling off and full resolution. `href`, `pix_out` and `win_err` are 0 during reset.
- R11: Programmable inputs become active only on a clock with `field_start`=1. That clock's own outputs still follow the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| field_start | input | 1 | One-clock pulse at each field start; loads settings |
| field_odd | input | 1 | Parity of the field starting now (1 = odd) |
| pix_col | input | COL_W | Column counter |
| pix_row | input | ROW_W | Row counter |
| pix_in | input | DW | Incoming pixel sample |
| cfg_hstart | input | 8 | Horizontal window start, coarse units |
| cfg_hend | input | 8 | Horizontal window end, coarse units |
| cfg_vstart | input | 8 | First row of window |
| cfg_vend | input | 8 | Row after last row of window |
| cfg_fmode | input | 2 | Field mode |
| cfg_skip | input | 6 | Field skip count N |
| cfg_shift | input | 8 | Pixel delay in clocks |
| cfg_dbl | input | 1 | Line doubling enable |
| cfg_qcif | input | 1 | Quarter resolution (one pixel per unit) |
| href | output | 1 | Registered line reference strobe |
| pix_out | output | DW | Delayed, doubled or blacked pixel data |
| win_err | output | 1 | Active window settings are illegal |

## Verification
The settings swap and the window decision can fall in the same clock. The bench places each `field_start` pulse on a column and row that lie inside the old window, with pixel data flowing. It expects that clock's `href` and `pix_out` to follow the old settings, and every following clock to follow the new ones. The shift change and a hidden field can also meet at that boundary: the clock after the pulse must already show black, while delayed samples from before the pulse must never reach the output.

// File: rtl/href_pkg.sv
package href_pkg;
  localparam int CFG_W = 8;

  typedef struct packed {
    logic [CFG_W-1:0] hstart;
    logic [CFG_W-1:0] hend;
    logic [CFG_W-1:0] vstart;
    logic [CFG_W-1:0] vend;
    logic [CFG_W-1:0] shift;
    logic [1:0]       fmode;
    logic [5:0]       skip;
    logic             dbl;
    logic             qcif;
  } href_cfg_t;

  localparam logic [1:0] FM_NONE = 2'b00;
  localparam logic [1:0] FM_ODD  = 2'b01;
  localparam logic [1:0] FM_EVEN = 2'b10;
  localparam logic [1:0] FM_BOTH = 2'b11;

  localparam logic [CFG_W-1:0] HS_MIN = 8'h38;
  localparam logic [CFG_W-1:0] HS_MAX = 8'hEB;
  localparam logic [CFG_W-1:0] HE_MIN = 8'h39;
  localparam logic [CFG_W-1:0] HE_MAX = 8'hEC;
  localparam logic [CFG_W-1:0] VS_MIN = 8'h03;
  localparam logic [CFG_W-1:0] VS_MAX = 8'h93;
  localparam logic [CFG_W-1:0] VE_MIN = 8'h04;
  localparam logic [CFG_W-1:0] VE_MAX = 8'h94;

  localparam href_cfg_t CFG_RESET = '{
    hstart: 8'h38, hend: 8'hEA, vstart: 8'h03, vend: 8'h92,
    shift: 8'h00, fmode: FM_BOTH, skip: 6'd1, dbl: 1'b0, qcif: 1'b0
  };

  function automatic logic cfg_legal(input href_cfg_t c);
    logic h_ok, v_ok;
    h_ok = (c.hstart >= HS_MIN) && (c.hstart <= HS_MAX) &&
           (c.hend >= HE_MIN) && (c.hend <= HE_MAX) && (c.hstart < c.hend);
    v_ok = (c.vstart >= VS_MIN) && (c.vstart <= VS_MAX) &&
           (c.vend >= VE_MIN) && (c.vend <= VE_MAX) && (c.vstart < c.vend);
    return h_ok && v_ok;
  endfunction
endpackage

// File: rtl/href_cfg_latch.sv
module href_cfg_latch
  import href_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      field_start,
  input  logic      field_odd,
  input  href_cfg_t cfg_in,
  output href_cfg_t act,
  output logic      field_en,
  output logic      sup
);
  localparam int PC_W = $bits(cfg_in.skip);

  logic            cur_odd;
  logic [PC_W-1:0] pass_cnt;
  logic [PC_W-1:0] n_eff;
  logic [PC_W:0]   pc_inc;
  logic            skip_mode;
  logic            parity_hit;

  always_comb begin
    n_eff      = (cfg_in.skip == '0) ? PC_W'(1) : cfg_in.skip;
    pc_inc     = {1'b0, pass_cnt} + (PC_W+1)'(1);
    skip_mode  = (cfg_in.fmode == FM_ODD) || (cfg_in.fmode == FM_EVEN);
    parity_hit = ((cfg_in.fmode == FM_ODD) && field_odd) ||
                 ((cfg_in.fmode == FM_EVEN) && !field_odd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= CFG_RESET;
      cur_odd  <= 1'b1;
      sup      <= 1'b0;
      pass_cnt <= '0;
    end else if (field_start) begin
      act     <= cfg_in;
      cur_odd <= field_odd;
      if (parity_hit) begin
        sup      <= (pass_cnt != '0);
        pass_cnt <= (pc_inc >= {1'b0, n_eff}) ? '0 : pc_inc[PC_W-1:0];
      end else begin
        sup <= 1'b0;
        if (!skip_mode) pass_cnt <= '0;
      end
    end
  end

  always_comb begin
    unique case (act.fmode)
      FM_NONE: field_en = 1'b0;
      FM_ODD:  field_en = cur_odd && !sup;
      FM_EVEN: field_en = !cur_odd && !sup;
      default: field_en = 1'b1;
    endcase
  end
endmodule

// File: rtl/href_window.sv
module href_window
  import href_pkg::*;
#(
  parameter int COL_W = 11,
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  href_cfg_t        act,
  input  logic             field_en,
  input  logic [COL_W-1:0] pix_col,
  input  logic [ROW_W-1:0] pix_row,
  output logic             href,
  output logic             win_err
);
  logic [1:0]       unit_sh;
  logic [COL_W-1:0] unit;
  logic             in_h, in_v, legal;

  always_comb begin
    unit_sh = {1'b0, !act.qcif} + {1'b0, act.dbl};
    unit    = pix_col >> unit_sh;
    in_h    = (unit >= COL_W'(act.hstart)) && (unit < COL_W'(act.hend));
    in_v    = (pix_row >= ROW_W'(act.vstart)) && (pix_row < ROW_W'(act.vend));
    legal   = cfg_legal(act);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      href    <= 1'b0;
      win_err <= 1'b0;
    end else begin
      href    <= legal && field_en && in_h && in_v;
      win_err <= !legal;
    end
  end
endmodule

// File: rtl/href_pix_delay.sv
module href_pix_delay #(
  parameter int          DW    = 8,
  parameter int          AW    = 8,
  parameter logic [DW-1:0] BLACK = 8'h10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] shift,
  input  logic          dbl,
  input  logic          sup,
  input  logic          col_lsb,
  input  logic [DW-1:0] pix_in,
  output logic [DW-1:0] pix_out
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ring [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] hold;
  logic [DW-1:0] d_now;

  always_comb begin
    d_now   = (dbl && col_lsb) ? hold : pix_in;
    rd_addr = wp - shift;
  end

  always_ff @(posedge clk) begin
    ring[wp] <= d_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      hold    <= '0;
      pix_out <= '0;
    end else begin
      wp      <= wp + AW'(1);
      hold    <= d_now;
      if (sup)               pix_out <= BLACK;
      else if (shift == '0)  pix_out <= d_now;
      else                   pix_out <= ring[rd_addr];
    end
  end
endmodule

// File: rtl/href_gate.sv
module href_gate
  import href_pkg::*;
#(
  parameter int            DW    = 8,
  parameter int            COL_W = 11,
  parameter int            ROW_W = 9,
  parameter logic [DW-1:0] BLACK = 8'h10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             field_start,
  input  logic             field_odd,
  input  logic [COL_W-1:0] pix_col,
  input  logic [ROW_W-1:0] pix_row,
  input  logic [DW-1:0]    pix_in,
  input  logic [7:0]       cfg_hstart,
  input  logic [7:0]       cfg_hend,
  input  logic [7:0]       cfg_vstart,
  input  logic [7:0]       cfg_vend,
  input  logic [1:0]       cfg_fmode,
  input  logic [5:0]       cfg_skip,
  input  logic [7:0]       cfg_shift,
  input  logic             cfg_dbl,
  input  logic             cfg_qcif,
  output logic             href,
  output logic [DW-1:0]    pix_out,
  output logic             win_err
);
  href_cfg_t cfg_in;
  href_cfg_t act;
  logic      field_en;
  logic      sup;

  always_comb begin
    cfg_in.hstart = cfg_hstart;
    cfg_in.hend   = cfg_hend;
    cfg_in.vstart = cfg_vstart;
    cfg_in.vend   = cfg_vend;
    cfg_in.shift  = cfg_shift;
    cfg_in.fmode  = cfg_fmode;
    cfg_in.skip   = cfg_skip;
    cfg_in.dbl    = cfg_dbl;
    cfg_in.qcif   = cfg_qcif;
  end

  href_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .field_start(field_start), .field_odd(field_odd),
    .cfg_in(cfg_in), .act(act), .field_en(field_en), .sup(sup)
  );

  href_window #(.COL_W(COL_W), .ROW_W(ROW_W)) u_win (
    .clk(clk), .rst(rst), .act(act), .field_en(field_en),
    .pix_col(pix_col), .pix_row(pix_row), .href(href), .win_err(win_err)
  );

  href_pix_delay #(.DW(DW), .AW(CFG_W), .BLACK(BLACK)) u_pix (
    .clk(clk), .rst(rst), .shift(act.shift), .dbl(act.dbl), .sup(sup),
    .col_lsb(pix_col[0]), .pix_in(pix_in), .pix_out(pix_out)
  );
endmodule

// File: rtl/href_gate_chk.sv
module href_gate_chk
  import href_pkg::*;
#(
  parameter int            DW    = 8,
  parameter int            ROW_W = 9,
  parameter logic [DW-1:0] BLACK = 8'h10
) (
  input logic             clk,
  input logic             rst,
  input logic             field_start,
  input logic [ROW_W-1:0] pix_row,
  input logic             href,
  input logic [DW-1:0]    pix_out,
  input logic             win_err,
  input href_cfg_t        act,
  input logic             sup
);
  AST_ERR_BLOCKS_HREF: assert property (@(posedge clk) disable iff (rst) win_err |-> !href); // R2
  AST_HREF_IN_ROWS: assert property (@(posedge clk) disable iff (rst) href |-> (($past(pix_row) >= ROW_W'($past(act.vstart))) && ($past(pix_row) < ROW_W'($past(act.vend))))); // R3
  AST_OFF_MODE_QUIET: assert property (@(posedge clk) disable iff (rst) (act.fmode == FM_NONE) |=> !href); // R4
  AST_HIDDEN_IS_BLACK: assert property (@(posedge clk) disable iff (rst) sup |=> (pix_out == BLACK) && !href); // R7
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst) !field_start |=> $stable(act)); // R11
endmodule

bind href_gate href_gate_chk #(.DW(DW), .ROW_W(ROW_W), .BLACK(BLACK)) u_chk (
  .clk(clk), .rst(rst), .field_start(field_start), .pix_row(pix_row),
  .href(href), .pix_out(pix_out), .win_err(win_err), .act(act), .sup(sup)
);

// File: tb/href_gate_bench.sv
module href_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, COL_W = 11, ROW_W = 9;
  localparam logic [DW-1:0] BLACK = 8'h10;

  logic clk = 0, rst = 1, field_start = 0, field_odd = 1;
  logic [COL_W-1:0] pix_col = '0;
  logic [ROW_W-1:0] pix_row = '0;
  logic [DW-1:0] pix_in = '0;
  logic [7:0] c_hs = 8'h38, c_he = 8'hEA, c_vs = 8'h03, c_ve = 8'h92, c_sh = 0;
  logic [1:0] c_fm = 2'b11;
  logic [5:0] c_sk = 6'd1;
  logic c_dbl = 0, c_qcif = 0;
  logic href, win_err;
  logic [DW-1:0] pix_out;

  href_gate #(.DW(DW), .COL_W(COL_W), .ROW_W(ROW_W), .BLACK(BLACK)) u_href_gate (
    .clk(clk), .rst(rst), .field_start(field_start), .field_odd(field_odd),
    .pix_col(pix_col), .pix_row(pix_row), .pix_in(pix_in),
    .cfg_hstart(c_hs), .cfg_hend(c_he), .cfg_vstart(c_vs), .cfg_vend(c_ve),
    .cfg_fmode(c_fm), .cfg_skip(c_sk), .cfg_shift(c_sh), .cfg_dbl(c_dbl),
    .cfg_qcif(c_qcif), .href(href), .pix_out(pix_out), .win_err(win_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  string cur_req = "R10";
  int m_hs, m_he, m_vs, m_ve, m_sh, m_fm, m_sk, m_dbl, m_qcif, m_odd, m_sup, m_pc;
  int m_hold, t, since_rst;
  int hist [512];
  bit pend = 0, e_href, e_err, e_pix_on;
  int e_pix;

  task automatic chk(input bit ok, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got=%0h exp=%0h t=%0d", cur_req, what, got, exp, t);
    end
  endtask

  function automatic bit legal_m();
    return m_hs >= 'h38 && m_hs <= 'hEB && m_he >= 'h39 && m_he <= 'hEC && m_hs < m_he &&
           m_vs >= 3 && m_vs <= 'h93 && m_ve >= 4 && m_ve <= 'h94 && m_vs < m_ve;
  endfunction

  function automatic bit fen_m();
    bit f;
    case (m_fm)
      0: f = 0;
      1: f = (m_odd == 1);
      2: f = (m_odd == 0);
      default: f = 1;
    endcase
    return f && (m_sup == 0);
  endfunction

  task automatic model_reset();
    m_hs = 'h38; m_he = 'hEA; m_vs = 3; m_ve = 'h92; m_sh = 0; m_fm = 3; m_sk = 1;
    m_dbl = 0; m_qcif = 0; m_odd = 1; m_sup = 0; m_pc = 0; m_hold = 0; t = 0; since_rst = 0;
    pend = 0;
  endtask

  task automatic step(input int col, input int row, input bit fs, input bit odd);
    int smp, u, n;
    @(negedge clk);
    if (pend) begin
      chk(href === e_href, "href", int'(href), int'(e_href));
      chk(win_err === e_err, "win_err", int'(win_err), int'(e_err));
      if (e_pix_on) chk(pix_out === DW'(e_pix), "pix_out", int'(pix_out), e_pix);
    end
    pix_col = COL_W'(col); pix_row = ROW_W'(row); field_start = fs; field_odd = odd;
    pix_in = DW'(col * 3 + row * 11 + t);
    smp = (m_dbl == 1 && (col % 2) == 1) ? m_hold : int'(pix_in);
    m_hold = smp;
    hist[t % 512] = smp;
    u = col >> ((m_qcif == 1 ? 0 : 1) + m_dbl);
    e_href = legal_m() && fen_m() && u >= m_hs && u < m_he && row >= m_vs && row < m_ve;
    e_err = !legal_m();
    e_pix_on = (since_rst >= 260) || (m_sup == 1);
    e_pix = (m_sup == 1) ? int'(BLACK) : hist[(t - m_sh + 512) % 512];
    pend = 1;
    if (fs) begin
      m_hs = c_hs; m_he = c_he; m_vs = c_vs; m_ve = c_ve; m_sh = c_sh; m_fm = c_fm;
      m_sk = c_sk; m_dbl = c_dbl; m_qcif = c_qcif; m_odd = odd;
      if ((c_fm == 1 && odd) || (c_fm == 2 && !odd)) begin
        m_sup = (m_pc != 0);
        n = (c_sk == 0) ? 1 : int'(c_sk);
        m_pc = (m_pc + 1 >= n) ? 0 : m_pc + 1;
      end else begin
        m_sup = 0;
        if (c_fm == 0 || c_fm == 3) m_pc = 0;
      end
    end
    t++; since_rst++;
  endtask

  task automatic sweep(input int rlo, input int rhi, input int cmax, input bit odd);
    for (int r = rlo; r <= rhi; r++)
      for (int c = 0; c <= cmax; c++) step(c, r, 0, odd);
  endtask

  // Field start placed inside the old window to provoke the boundary case (R11).
  task automatic field(input bit odd, input int rlo, input int rhi, input int cmax);
    step((m_hs << ((m_qcif == 1 ? 0 : 1) + m_dbl)), m_vs, 1, odd);
    sweep(rlo, rhi, cmax, odd);
  endtask

  task automatic setw(input int hs, input int he, input int vs, input int ve);
    c_hs = 8'(hs); c_he = 8'(he); c_vs = 8'(vs); c_ve = 8'(ve);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    cur_req = "R10";
    chk(href === 1'b0, "reset href", int'(href), 0);
    chk(pix_out === '0, "reset pix_out", int'(pix_out), 0);
    chk(win_err === 1'b0, "reset win_err", int'(win_err), 0);
    rst = 0;
    sweep(2, 3, 'hEB * 2 + 2, 1);
    sweep('h91, 'h92, 'hEB * 2 + 2, 1);

    cur_req = "R1"; setw('h40, 'h44, 5, 8); c_fm = 3; c_sk = 1;
    field(1, 3, 9, 'h46 * 2);
    c_qcif = 1; field(0, 3, 9, 'h46);
    c_qcif = 0;
    cur_req = "R9"; c_dbl = 1; field(1, 4, 6, 'h46 * 4);
    c_qcif = 1; field(0, 4, 6, 'h46 * 2);
    c_qcif = 0; c_dbl = 0;
    cur_req = "R8"; c_sh = 3; field(1, 4, 6, 'h46 * 2);
    c_sh = 8'h20; field(0, 4, 6, 'h46 * 2);
    c_sh = 8'hFF; c_dbl = 1; field(1, 4, 7, 'h46 * 4);
    c_dbl = 0; c_sh = 0;

    cur_req = "R2";
    setw('h37, 'h44, 5, 8); field(1, 4, 6, 'h46 * 2);
    setw('h44, 'h44, 5, 8); field(1, 4, 6, 'h46 * 2);
    setw('hEB, 'hED, 5, 8); field(1, 4, 5, 'hEE * 2);
    setw('hEC, 'hEC, 5, 8); field(1, 4, 5, 'hEE * 2);
    setw('h38, 'h39, 5, 8); field(1, 4, 6, 'h3A * 2);
    setw('hEB, 'hEC, 5, 8); field(1, 4, 6, 'hED * 2);
    cur_req = "R3";
    setw('h40, 'h44, 2, 8); field(1, 1, 4, 'h46 * 2);
    setw('h40, 'h44, 5, 5); field(1, 4, 6, 'h46 * 2);
    setw('h40, 'h44, 'h90, 'h95); field(1, 'h93, 'h95, 'h46 * 2);
    setw('h40, 'h44, 'h93, 'h94); field(1, 'h92, 'h95, 'h46 * 2);
    setw('h40, 'h44, 3, 4); field(1, 2, 5, 'h46 * 2);

    cur_req = "R4"; setw('h40, 'h42, 5, 7);
    c_fm = 0; field(1, 4, 7, 'h43 * 2); field(0, 4, 7, 'h43 * 2);
    c_fm = 1; field(1, 4, 7, 'h43 * 2); field(0, 4, 7, 'h43 * 2);
    c_fm = 2; field(1, 4, 7, 'h43 * 2); field(0, 4, 7, 'h43 * 2);

    cur_req = "R5"; c_fm = 1; c_sk = 3; c_sh = 5;
    field(1, 4, 7, 'h43 * 2); field(0, 4, 7, 'h43 * 2);
    cur_req = "R7"; field(1, 4, 7, 'h43 * 2); field(1, 4, 7, 'h43 * 2);
    cur_req = "R5"; field(1, 4, 7, 'h43 * 2); field(1, 4, 7, 'h43 * 2);
    c_fm = 2; c_sk = 0; field(0, 4, 6, 'h43 * 2); field(0, 4, 6, 'h43 * 2);
    c_sk = 2; field(0, 4, 6, 'h43 * 2); field(1, 4, 6, 'h43 * 2); field(0, 4, 6, 'h43 * 2);
    field(0, 4, 6, 'h43 * 2);

    cur_req = "R6"; c_fm = 3; c_sk = 3;
    field(1, 4, 6, 'h43 * 2); field(1, 4, 6, 'h43 * 2); field(0, 4, 6, 'h43 * 2);
    c_fm = 0; c_sk = 2; field(1, 4, 6, 'h43 * 2);
    c_fm = 1; field(1, 4, 6, 'h43 * 2); field(1, 4, 6, 'h43 * 2);

    cur_req = "R11"; c_fm = 3; c_sk = 1; c_sh = 2; setw('h40, 'h44, 5, 8);
    field(1, 4, 8, 'h46 * 2);
    setw('h37, 'h50, 2, 3); c_fm = 0; c_sh = 9; c_qcif = 1;
    sweep(4, 8, 'h46 * 2, 1);
    c_qcif = 0; c_sh = 0;
    field(1, 4, 8, 'h46 * 2);
    step(0, 0, 0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule